// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resamples one image line horizontally. It takes a line of 8-bit samples on a valid/ready input stream and produces a programmable number of output samples on a valid-only output stream. The last output sample of the line is flagged. Each output sample comes from an 8-tap FIR filter. Its coefficients are picked from one of 32 phases by the fractional position of a 16.16 fixed-point accumulator. The accumulator starts each line at a programmable signed seed and advances by a programmable step. For a plain resize, the step is normally (input width << 16) / output width.

The whole input line is captured first, with the input ready. The output samples then stream out one per cycle while the input is held off. Coefficients are written into a staging bank through a simple word write port. They reach the filter only after a commit pulse. A commit that arrives while a line is being emitted waits until that line is finished. After reset the active bank holds a pass-through filter.

Top module: `hscale_poly`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0. Every phase of the active bank holds a single tap of 64 at tap 3 and zero elsewhere, so each output equals the input sample at the accumulator's integer position.
- R2: While loading, `s_ready` is 1 and samples are taken on cycles with `s_valid` high, with gaps allowed. After the `cfg_in_w`-th sample is taken, `s_ready` is 0 on the next cycle and stays 0 until the line's output is complete.
- R3: Output starts on the cycle after the last input sample is taken. It is exactly `cfg_out_w` consecutive cycles of `m_valid` high, with `m_last` high only on the final one. On the following cycle `s_ready` is 1 and `m_valid` is 0.
- R4: A signed 32-bit accumulator is loaded with `cfg_phase0` for the first output and increases by `cfg_step` after every output. Bits 31:16, read as signed, give the centre sample index. Bits 15:11 give the phase (0..31).
- R5: Tap k (0..7) multiplies the sample at index centre+k-3. For phase p, taps 0..3 are the bytes of coefficient word 2p from bits 7:0 up to bits 31:24, and taps 4..7 are the bytes of word 2p+1 in the same order. Taps are signed 8-bit and samples are unsigned.
- R6: An index below 0 uses sample 0, and an index above `cfg_in_w`-1 uses the last sample of the line.
- R7: The tap sum has 32 added and is shifted right arithmetically by 6. The result is clamped to 0..255: negative results give 0 and results above 255 give 255.
- R8: A write with `coef_we` high stores `coef_wdata` into staging word `coef_addr` and does not change the filter. A one-cycle `coef_ready` pulse copies all 64 staging words to the active bank. The copy happens at once when no line is being emitted. If a line is being emitted, the copy waits for the end of that line, so the line keeps its old coefficients and the next line uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in_w | input | 7 | Input samples per line (1..MAX_W), held during a line |
| cfg_out_w | input | 7 | Output samples per line (>=1), held during a line |
| cfg_step | input | 32 | 16.16 accumulator increment per output |
| cfg_phase0 | input | 32 | Signed 16.16 accumulator seed for each line |
| coef_we | input | 1 | Staging coefficient write strobe |
| coef_addr | input | 6 | Staging word address, 2*phase + word |
| coef_wdata | input | 32 | Four signed taps, lowest tap in bits 7:0 |
| coef_ready | input | 1 | Commit pulse: staging to active |
| s_valid | input | 1 | Input sample valid |
| s_data | input | 8 | Input sample |
| s_ready | output | 1 | Input accepted when high |
| m_valid | output | 1 | Output sample valid |
| m_data | output | 8 | Output sample |
| m_last | output | 1 | Last output of the line |

## Verification
The bench sweeps widths from a single-sample line to a full 64-sample line, covering equal, upscaled and downscaled ratios. It uses a negative seed that drives the centre index below zero and steps that run past the right edge. If edge replication were wrong, the outputs near either border would mismatch, or taps would read stale buffer entries. Random full-range coefficients push the sum past both clamp limits, which exposes a missing clamp or a wrong rounding shift. Uncommitted staging writes and a commit issued mid-line show whether the filter picks up coefficients too early. Reversed tap order or a swapped word half shows up as wrong values at every non-zero phase.

// File: rtl/hscale_poly.sv
module hscale_poly #(
  parameter int MAX_W  = 64,
  parameter int DW     = 8,
  parameter int PHASES = 32,
  parameter int ACC_W  = 32,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int AW = $clog2(MAX_W),
  localparam int PB = $clog2(PHASES),
  localparam int CA = PB + 1,
  localparam int NW = 2 * PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WW-1:0]     cfg_in_w,
  input  logic [WW-1:0]     cfg_out_w,
  input  logic [ACC_W-1:0]  cfg_step,
  input  logic [ACC_W-1:0]  cfg_phase0,
  input  logic              coef_we,
  input  logic [CA-1:0]     coef_addr,
  input  logic [31:0]       coef_wdata,
  input  logic              coef_ready,
  input  logic              s_valid,
  input  logic [DW-1:0]     s_data,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DW-1:0]     m_data,
  output logic              m_last
);
  localparam int TAPS = 8;
  localparam int MAXV = (1 << DW) - 1;

  logic [DW-1:0]    line_q  [MAX_W];
  logic [31:0]      stage_q [NW];
  logic [31:0]      coef_q  [NW];
  logic             emit_q, pend_q;
  logic [WW-1:0]    cnt_q;
  logic [ACC_W-1:0] acc_q;

  assign s_ready = !emit_q;
  assign m_valid = emit_q;
  assign m_last  = emit_q && (cnt_q == cfg_out_w - WW'(1));

  wire take     = s_valid && !emit_q;
  wire last_in  = cnt_q == cfg_in_w - WW'(1);
  wire do_apply = pend_q && !emit_q;

  always_ff @(posedge clk)
    if (take) line_q[cnt_q[AW-1:0]] <= s_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emit_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (!emit_q) begin
      if (s_valid) begin
        if (last_in) begin
          emit_q <= 1'b1;
          cnt_q  <= '0;
          acc_q  <= cfg_phase0;
        end else begin
          cnt_q <= cnt_q + WW'(1);
        end
      end
    end else begin
      acc_q <= acc_q + cfg_step;
      if (m_last) begin
        emit_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + WW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        stage_q[i] <= '0;
        coef_q[i]  <= (i % 2 == 0) ? 32'h4000_0000 : 32'h0;
      end
    end else begin
      if (coef_we) stage_q[coef_addr] <= coef_wdata;
      if (coef_ready) pend_q <= 1'b1;
      else if (do_apply) pend_q <= 1'b0;
      if (do_apply)
        for (int i = 0; i < NW; i++) coef_q[i] <= stage_q[i];
    end
  end

  logic [PB-1:0] phase;
  logic signed [ACC_W-17:0] centre;
  assign phase  = acc_q[15 -: PB];
  assign centre = $signed(acc_q[ACC_W-1:16]);

  always_comb begin
    int sum, rnd, idx, widx;
    logic [31:0] word;
    sum = 0;
    for (int k = 0; k < TAPS; k++) begin
      idx = int'(centre) + k - 3;
      if (idx < 0) idx = 0;
      if (idx > int'(cfg_in_w) - 1) idx = int'(cfg_in_w) - 1;
      widx = 2 * int'(phase) + k / 4;
      word = coef_q[widx[CA-1:0]];
      sum  = sum + int'($signed(word[8*(k%4) +: 8])) * int'({1'b0, line_q[idx[AW-1:0]]});
    end
    rnd = (sum + 32) >>> 6;
    if (rnd < 0)         m_data = '0;
    else if (rnd > MAXV) m_data = DW'(MAXV);
    else                 m_data = rnd[DW-1:0];
  end
endmodule

// File: rtl/hscale_poly_chk.sv
module hscale_poly_chk #(
  parameter int WW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [WW-1:0] cfg_in_w,
  input logic [WW-1:0] cfg_out_w,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_last
);
  logic [WW-1:0] n_in, n_out;
  wire acc_last = s_valid && s_ready && (n_in == cfg_in_w - WW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (s_valid && s_ready) n_in <= acc_last ? '0 : n_in + WW'(1);
      if (m_valid) n_out <= m_last ? '0 : n_out + WW'(1);
    end
  end

  assert_load_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !acc_last) |=> s_ready);
  assert_emit_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last |=> (m_valid && !s_ready));
  assert_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |=> m_valid);
  assert_last_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> (n_out == cfg_out_w - WW'(1)));
  assert_line_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |=> (s_ready && !m_valid));
endmodule

bind hscale_poly hscale_poly_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_in_w(cfg_in_w), .cfg_out_w(cfg_out_w),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid), .m_last(m_last)
);

// File: tb/tb_hscale_poly.sv
module tb_hscale_poly;
  logic clk = 0, rst_n = 0;
  logic [6:0] cfg_in_w = 1, cfg_out_w = 1;
  logic [31:0] cfg_step = 0, cfg_phase0 = 0;
  logic coef_we = 0, coef_ready = 0, s_valid = 0;
  logic [5:0] coef_addr = 0;
  logic [31:0] coef_wdata = 0;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  hscale_poly dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] stage_m [64];
  logic [31:0] act_m [64];
  logic [7:0] smp [64];
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int j, int in_w, int step, int ph0);
    int acc, c, ph, sum, idx, r;
    logic [31:0] w;
    acc = ph0 + j * step;
    c = acc >>> 16;
    ph = (acc >> 11) & 31;
    sum = 0;
    for (int k = 0; k < 8; k++) begin
      idx = c + k - 3;
      if (idx < 0) idx = 0;
      if (idx > in_w - 1) idx = in_w - 1;
      w = act_m[2 * ph + k / 4];
      sum += int'($signed(w[8*(k%4) +: 8])) * int'(smp[idx]);
    end
    r = (sum + 32) >>> 6;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic logic [31:0] nxt();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic write_stage(int mode);
    for (int a = 0; a < 64; a++) begin
      logic [31:0] w;
      int p;
      p = a / 2;
      if (mode == 0) w = nxt();
      else if (a % 2 == 0) w = {8'(64 - p), 8'(-(p >> 2)), 16'h0};
      else w = {24'h0, 8'(p + (p >> 2))};
      @(negedge clk);
      coef_we = 1; coef_addr = 6'(a); coef_wdata = w;
      stage_m[a] = w;
    end
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic commit_idle();
    @(negedge clk); coef_ready = 1;
    @(negedge clk); coef_ready = 0;
    for (int a = 0; a < 64; a++) act_m[a] = stage_m[a];
  endtask

  task automatic run_line(int in_w, int out_w, int ph0, int commit_at, string tag);
    int step;
    step = (in_w << 16) / out_w;
    cfg_in_w = 7'(in_w); cfg_out_w = 7'(out_w);
    cfg_step = step; cfg_phase0 = ph0;
    for (int i = 0; i < in_w; i++) smp[i] = 8'(nxt());
    for (int i = 0; i < in_w; i++) begin
      @(negedge clk);
      if (i % 5 == 2) begin
        s_valid = 0;
        @(negedge clk);
      end
      chk(s_ready == 1, "R2 ready during load", s_ready, 1);
      s_valid = 1; s_data = smp[i];
    end
    @(negedge clk);
    s_valid = 0;
    chk(s_ready == 0, "R2 ready low after last sample", s_ready, 0);
    for (int j = 0; j < out_w; j++) begin
      int e;
      e = model(j, in_w, step, ph0);
      chk(m_valid == 1, "R3 valid run", m_valid, 1);
      chk(m_last == (j == out_w - 1), "R3 last flag", m_last, int'(j == out_w - 1));
      chk(m_data == 8'(e), tag, m_data, e);
      coef_ready = (j == commit_at);
      @(negedge clk);
      coef_ready = 0;
    end
    chk(m_valid == 0, "R3 valid drops", m_valid, 0);
    chk(s_ready == 1, "R3 ready returns", s_ready, 1);
    if (commit_at >= 0)
      for (int a = 0; a < 64; a++) act_m[a] = stage_m[a];
  endtask

  initial begin
    for (int a = 0; a < 64; a++) begin
      act_m[a] = (a % 2 == 0) ? 32'h4000_0000 : 32'h0;
      stage_m[a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready == 1, "R1 reset ready", s_ready, 1);
    chk(m_valid == 0, "R1 reset valid", m_valid, 0);
    run_line(8, 8, 32'h400, -1, "R1 pass-through after reset");
    run_line(10, 23, 0, -1, "R1/R4 pass-through upscale");
    write_stage(0);
    run_line(12, 12, 0, -1, "R8 staging not used before commit");
    commit_idle();
    run_line(16, 16, 0, -1, "R5 R7 equal width");
    run_line(16, 40, 32'h400, -1, "R4 R5 upscale");
    run_line(40, 13, 0, -1, "R4 R7 downscale");
    run_line(5, 23, -32'sh4000, -1, "R6 negative seed left edge");
    run_line(64, 64, 0, -1, "R6 full line right edge");
    run_line(1, 6, 0, -1, "R6 single sample line");
    write_stage(1);
    run_line(20, 50, 32'hC000, 3, "R8 old bank kept during mid-line commit");
    run_line(20, 50, 32'hC000, -1, "R8 new bank after deferred commit");
    run_line(33, 17, 32'h400, -1, "R5 smooth downscale");
    run_line(3, 64, 0, -1, "R6 R4 heavy upscale");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule